// File: doc/BRIEF.md
# I/O Error Containment Controller

This block sits between a processor-side request port and an I/O fabric. Every programmed load, store and configuration read passes through it on the way out. Every completion that comes back, including completions for inbound DMA, is classified here by operation, status and the containment setting of the target endpoint. From that classification the block decides one of four outcomes: hand the load data back, substitute all-ones, raise a machine check on every processor at once, or freeze the endpoint.

Containment is enabled one endpoint at a time. With containment on, an error freezes the endpoint instead of raising a machine check. A frozen endpoint absorbs its later traffic without any error effect. Stores to it never reach the fabric. Reads to it still travel, but always come back as all-ones. Software clears the frozen state with a per-endpoint clear pulse. Adapters also report fatal conditions on a per-endpoint line. These follow the same rule: freeze when contained, machine check when not.

Top module: `io_contain_ctrl`

## Requirements
- R1: After reset every endpoint's stopped flag is 0, all machine-check outputs are 0 and `rsp_valid` is 0.
- R2: Operation codes are load=0, store=1, config read=2, DMA=3, and status codes are ok=0, no-response=1, error=2 (3 acts as error). A load completion with status ok on a running endpoint gives `rsp_valid`=1 with `rsp_data`=`cpl_data` and `rsp_cfg_ok`=0 on the cycle after the completion, with no machine check.
- R3: A load with no-response returns all-ones data. A store with no-response produces no response. In both cases no machine check is raised and the endpoint is not stopped.
- R4: A load, store or DMA error on a running endpoint whose containment is off raises a machine check on the cycle after the completion and does not stop the endpoint. A load in this case returns all-ones.
- R5: A load error on a running endpoint whose containment is on returns all-ones, sets that endpoint's stopped flag on the next cycle, and raises no machine check.
- R6: A store or DMA error on a running endpoint whose containment is on sets its stopped flag on the next cycle and raises no machine check.
- R7: A fatal pulse from the adapter of a running endpoint stops that endpoint if its containment is on. Otherwise it raises a machine check.
- R8: A machine check drives all `NUM_CPU` outputs high together for exactly one cycle. Any number of causes in the same cycle produce a single one-cycle pulse.
- R9: A store request to a stopped endpoint is not forwarded (`fab_req_valid`=0 in the same cycle). Requests of any type to running endpoints, and loads to stopped ones, are forwarded in the same cycle with their operation and endpoint unchanged.
- R10: A load or config-read completion for a stopped endpoint returns all-ones with `rsp_cfg_ok`=0. No completion or fatal pulse for a stopped endpoint raises a machine check.
- R11: A config read with status ok returns `cpl_data` with `rsp_cfg_ok`=1. With no-response it returns all-ones with `rsp_cfg_ok`=1 and does not stop the endpoint. With error it returns all-ones with `rsp_cfg_ok`=0, and stops or raises a machine check as in R4/R5.
- R12: A pulse on `clr_stop[i]` clears endpoint i's stopped flag on the next cycle. If a stop event for i arrives in the same cycle, the stop wins.
- R13: A DMA completion with status ok or no-response has no effect: no response, no machine check, no stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| contain_en | input | NUM_EP | Per-endpoint containment enable |
| req_valid | input | 1 | Processor request valid |
| req_op | input | 2 | Request operation code |
| req_ep | input | EP_W | Request target endpoint |
| fab_req_valid | output | 1 | Request forwarded to the fabric |
| fab_req_op | output | 2 | Forwarded operation code |
| fab_req_ep | output | EP_W | Forwarded endpoint |
| cpl_valid | input | 1 | Completion valid |
| cpl_op | input | 2 | Operation the completion belongs to |
| cpl_ep | input | EP_W | Endpoint the completion belongs to |
| cpl_status | input | 2 | Completion status code |
| cpl_data | input | DW | Read data from the fabric |
| fatal_err | input | NUM_EP | Per-endpoint adapter fatal pulse |
| clr_stop | input | NUM_EP | Per-endpoint stopped-state clear pulse |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read response data |
| rsp_cfg_ok | output | 1 | Config read reported as success |
| mc_out | output | NUM_CPU | Machine-check pulse, one bit per processor |
| ep_stopped | output | NUM_EP | Per-endpoint stopped flags |

## Verification
A stopped flag left set by mistake would surface on the cycle after it was set. Loads to that endpoint would turn to all-ones and stores would vanish from the fabric port at once. A flag that failed to set would let the next error on that endpoint raise a machine check one cycle later instead of being absorbed. A wrong decision on a single completion is visible on the very next cycle, in `rsp_data`, `mc_out` or `ep_stopped`. The tests aim each status/containment/stopped combination at an endpoint and read all three outputs on that cycle and the one after.

// File: rtl/io_contain_pkg.sv
package io_contain_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CFGRD = 2'd2,
    OP_DMA   = 2'd3
  } ic_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NORSP = 2'd1,
    ST_ERR   = 2'd2,
    ST_RSVD  = 2'd3
  } ic_status_e;

  // Outcome of one completion
  typedef struct packed {
    logic rsp;     // a read response is produced
    logic ones;    // response data is forced to all-ones
    logic cfg_ok;  // success flag for config reads
    logic mc;      // machine check request
    logic stop;    // freeze the endpoint
  } ic_dec_t;

  function automatic logic ic_is_read(input ic_op_e op);
    return (op == OP_LOAD) || (op == OP_CFGRD);
  endfunction

  // Decision for a completion, given containment and current frozen state
  function automatic ic_dec_t ic_decide(input ic_op_e op, input ic_status_e st,
                                        input logic en, input logic stopped);
    ic_dec_t d;
    d     = '0;
    d.rsp = ic_is_read(op);
    if (stopped) begin
      d.ones = 1'b1;
    end else begin
      case (st)
        ST_OK: begin
          d.cfg_ok = (op == OP_CFGRD);
        end
        ST_NORSP: begin
          d.ones   = 1'b1;
          d.cfg_ok = (op == OP_CFGRD);
        end
        default: begin
          d.ones = 1'b1;
          if (en) d.stop = 1'b1;
          else    d.mc   = 1'b1;
        end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/ic_classify.sv
module ic_classify
  import io_contain_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              cpl_valid,
  input  logic [1:0]        cpl_op,
  input  logic [EP_W-1:0]   cpl_ep,
  input  logic [1:0]        cpl_status,
  input  logic [NUM_EP-1:0] contain_en,
  input  logic [NUM_EP-1:0] stopped,
  input  logic [NUM_EP-1:0] fatal_err,
  output ic_dec_t           cpl_dec,
  output logic [NUM_EP-1:0] set_stop,
  output logic              mc_evt
);

  logic [NUM_EP-1:0] fatal_stop;
  logic [NUM_EP-1:0] fatal_mc;
  logic [NUM_EP-1:0] cpl_stop;

  always_comb begin
    cpl_dec = '0;
    if (cpl_valid)
      cpl_dec = ic_decide(ic_op_e'(cpl_op), ic_status_e'(cpl_status),
                          contain_en[cpl_ep], stopped[cpl_ep]);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_ep
      assign fatal_stop[g] = fatal_err[g] & contain_en[g] & ~stopped[g];
      assign fatal_mc[g]   = fatal_err[g] & ~contain_en[g] & ~stopped[g];
      assign cpl_stop[g]   = cpl_dec.stop & (cpl_ep == EP_W'(g));
    end
  endgenerate

  assign set_stop = fatal_stop | cpl_stop;
  assign mc_evt   = cpl_dec.mc | (|fatal_mc);

endmodule

// File: rtl/ic_stop_regs.sv
module ic_stop_regs #(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] set_stop,
  input  logic [NUM_EP-1:0] clr_stop,
  output logic [NUM_EP-1:0] stop_q
);

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           stop_q[g] <= 1'b0;
        else if (set_stop[g]) stop_q[g] <= 1'b1;
        else if (clr_stop[g]) stop_q[g] <= 1'b0;
      end

      AST_STOP_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q[g]) |-> $past(set_stop[g])); // R12
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stop[g] && clr_stop[g]) |=> stop_q[g]); // R12
    end
  endgenerate

endmodule

// File: rtl/ic_mc_fanout.sv
module ic_mc_fanout #(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mc_evt,
  output logic [NUM_CPU-1:0] mc_out
);

  logic mc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc_q <= 1'b0;
    else        mc_q <= mc_evt;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CPU; g++) begin : g_cpu
      assign mc_out[g] = mc_q;
    end
  endgenerate

  AST_MC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_out[0] |-> $past(mc_evt)); // R8

endmodule

// File: rtl/io_contain_ctrl.sv
module io_contain_ctrl
  import io_contain_pkg::*;
#(
  parameter int NUM_EP  = 8,
  parameter int NUM_CPU = 4,
  parameter int DW      = 64,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EP-1:0]  contain_en,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [EP_W-1:0]    req_ep,
  output logic               fab_req_valid,
  output logic [1:0]         fab_req_op,
  output logic [EP_W-1:0]    fab_req_ep,
  input  logic               cpl_valid,
  input  logic [1:0]         cpl_op,
  input  logic [EP_W-1:0]    cpl_ep,
  input  logic [1:0]         cpl_status,
  input  logic [DW-1:0]      cpl_data,
  input  logic [NUM_EP-1:0]  fatal_err,
  input  logic [NUM_EP-1:0]  clr_stop,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_cfg_ok,
  output logic [NUM_CPU-1:0] mc_out,
  output logic [NUM_EP-1:0]  ep_stopped
);

  ic_dec_t           cpl_dec;
  logic [NUM_EP-1:0] set_stop;
  logic              mc_evt;
  logic              store_blocked;

  ic_classify #(.NUM_EP(NUM_EP)) u_classify (
    .cpl_valid  (cpl_valid),
    .cpl_op     (cpl_op),
    .cpl_ep     (cpl_ep),
    .cpl_status (cpl_status),
    .contain_en (contain_en),
    .stopped    (ep_stopped),
    .fatal_err  (fatal_err),
    .cpl_dec    (cpl_dec),
    .set_stop   (set_stop),
    .mc_evt     (mc_evt)
  );

  ic_stop_regs #(.NUM_EP(NUM_EP)) u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_stop (set_stop),
    .clr_stop (clr_stop),
    .stop_q   (ep_stopped)
  );

  ic_mc_fanout #(.NUM_CPU(NUM_CPU)) u_mc (
    .clk    (clk),
    .rst_n  (rst_n),
    .mc_evt (mc_evt),
    .mc_out (mc_out)
  );

  // Outbound request path: stores to a frozen endpoint are swallowed
  assign store_blocked = (ic_op_e'(req_op) == OP_STORE) && ep_stopped[req_ep];
  assign fab_req_valid = req_valid && !store_blocked;
  assign fab_req_op    = req_op;
  assign fab_req_ep    = req_ep;

  // Read response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_cfg_ok <= 1'b0;
    end else begin
      rsp_valid <= cpl_dec.rsp;
      if (cpl_dec.rsp) begin
        rsp_data   <= cpl_dec.ones ? {DW{1'b1}} : cpl_data;
        rsp_cfg_ok <= cpl_dec.cfg_ok;
      end
    end
  end

  AST_MC_ALL_CPUS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mc_out) == 0) || ($countones(mc_out) == NUM_CPU)); // R8
  AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 && ep_stopped[req_ep]) |-> !fab_req_valid); // R9
  AST_STOPPED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && ep_stopped[cpl_ep] && (cpl_op == 2'd0 || cpl_op == 2'd2))
      |=> (rsp_valid && rsp_data == {DW{1'b1}} && !rsp_cfg_ok)); // R10
  AST_CONTAINED_NO_MC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status[1] && contain_en[cpl_ep]
      && ((fatal_err & ~contain_en & ~ep_stopped) == '0)) |=> (mc_out == '0)); // R5
  AST_NORSP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status == 2'd1 && fatal_err == '0 && clr_stop == '0)
      |=> (ep_stopped == $past(ep_stopped) && mc_out == '0)); // R3

endmodule

// File: tb/io_contain_ctrl_tb.sv
module io_contain_ctrl_tb;

  localparam int NUM_EP  = 8;
  localparam int NUM_CPU = 4;
  localparam int DW      = 64;
  localparam int EP_W    = 3;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EP-1:0]  contain_en = '0;
  logic               req_valid = 1'b0;
  logic [1:0]         req_op = '0;
  logic [EP_W-1:0]    req_ep = '0;
  logic               fab_req_valid;
  logic [1:0]         fab_req_op;
  logic [EP_W-1:0]    fab_req_ep;
  logic               cpl_valid = 1'b0;
  logic [1:0]         cpl_op = '0;
  logic [EP_W-1:0]    cpl_ep = '0;
  logic [1:0]         cpl_status = '0;
  logic [DW-1:0]      cpl_data = '0;
  logic [NUM_EP-1:0]  fatal_err = '0;
  logic [NUM_EP-1:0]  clr_stop = '0;
  logic               rsp_valid;
  logic [DW-1:0]      rsp_data;
  logic               rsp_cfg_ok;
  logic [NUM_CPU-1:0] mc_out;
  logic [NUM_EP-1:0]  ep_stopped;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  io_contain_ctrl #(.NUM_EP(NUM_EP), .NUM_CPU(NUM_CPU), .DW(DW)) u_dut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one completion for a cycle, return at the negedge where its results are visible
  task automatic complete(input logic [1:0] op, input int ep, input logic [1:0] st,
                          input logic [DW-1:0] d);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_op = op; cpl_ep = EP_W'(ep); cpl_status = st; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_stop = '1;
    @(negedge clk);
    clr_stop = '0;
  endtask

  task automatic t_reset();
    chk("R1 stopped", DW'(ep_stopped), '0);
    chk("R1 mc", DW'(mc_out), '0);
    chk("R1 rsp_valid", DW'(rsp_valid), '0);
  endtask

  task automatic t_load_ok();
    complete(2'd0, 2, 2'd0, 64'h1234_5678_9abc_def0);
    chk("R2 rsp_valid", DW'(rsp_valid), 1);
    chk("R2 data", rsp_data, 64'h1234_5678_9abc_def0);
    chk("R2 cfg_ok", DW'(rsp_cfg_ok), 0);
    chk("R2 mc", DW'(mc_out), 0);
  endtask

  task automatic t_norsp();
    contain_en = 8'h04;
    complete(2'd0, 2, 2'd1, 64'h55);
    chk("R3 load ones", rsp_data, ONES);
    chk("R3 mc", DW'(mc_out), 0);
    chk("R3 stop", DW'(ep_stopped), 0);
    complete(2'd1, 2, 2'd1, 64'h0);
    chk("R3 store no rsp", DW'(rsp_valid), 0);
    chk("R3 store mc", DW'(mc_out), 0);
    chk("R3 store stop", DW'(ep_stopped), 0);
    contain_en = '0;
  endtask

  task automatic t_err_uncontained();
    complete(2'd0, 5, 2'd2, 64'h77);
    chk("R4 load mc", DW'(mc_out), DW'(4'hF));
    chk("R4 load ones", rsp_data, ONES);
    chk("R4 no stop", DW'(ep_stopped), 0);
    @(negedge clk);
    chk("R8 pulse width", DW'(mc_out), 0);
    complete(2'd1, 5, 2'd2, 64'h0);
    chk("R4 store mc", DW'(mc_out), DW'(4'hF));
    complete(2'd3, 5, 2'd3, 64'h0);
    chk("R4 dma mc", DW'(mc_out), DW'(4'hF));
    chk("R4 dma no stop", DW'(ep_stopped), 0);
  endtask

  task automatic t_err_contained();
    contain_en = 8'h0E;
    complete(2'd0, 1, 2'd2, 64'h99);
    chk("R5 ones", rsp_data, ONES);
    chk("R5 stop", DW'(ep_stopped), DW'(8'h02));
    chk("R5 mc", DW'(mc_out), 0);
    complete(2'd1, 2, 2'd2, 64'h0);
    chk("R6 store stop", DW'(ep_stopped), DW'(8'h06));
    chk("R6 store mc", DW'(mc_out), 0);
    complete(2'd3, 3, 2'd2, 64'h0);
    chk("R6 dma stop", DW'(ep_stopped), DW'(8'h0E));
    chk("R6 dma mc", DW'(mc_out), 0);
    contain_en = '0;
    clear_all();
  endtask

  task automatic t_fatal();
    contain_en = 8'h10;
    @(negedge clk);
    fatal_err = 8'h10;
    @(negedge clk);
    fatal_err = '0;
    chk("R7 contained stop", DW'(ep_stopped), DW'(8'h10));
    chk("R7 contained mc", DW'(mc_out), 0);
    fatal_err = 8'h20;
    @(negedge clk);
    fatal_err = '0;
    chk("R7 uncontained mc", DW'(mc_out), DW'(4'hF));
    chk("R7 uncontained no stop", DW'(ep_stopped), DW'(8'h10));
    fatal_err = 8'h10;
    @(negedge clk);
    fatal_err = '0;
    chk("R10 fatal on stopped no mc", DW'(mc_out), 0);
    contain_en = '0;
    clear_all();
  endtask

  task automatic t_mc_multi();
    @(negedge clk);
    fatal_err = 8'h01;
    cpl_valid = 1'b1; cpl_op = 2'd1; cpl_ep = 3'd6; cpl_status = 2'd2;
    @(negedge clk);
    fatal_err = '0; cpl_valid = 1'b0;
    chk("R8 single pulse high", DW'(mc_out), DW'(4'hF));
    @(negedge clk);
    chk("R8 single pulse low", DW'(mc_out), 0);
  endtask

  task automatic t_stopped_traffic();
    contain_en = 8'h80;
    complete(2'd1, 7, 2'd2, 64'h0);
    chk("R6 setup stop", DW'(ep_stopped), DW'(8'h80));
    req_valid = 1'b1; req_op = 2'd1; req_ep = 3'd7;
    #1;
    chk("R9 store dropped", DW'(fab_req_valid), 0);
    req_ep = 3'd6;
    #1;
    chk("R9 other ep forwarded", DW'(fab_req_valid), 1);
    chk("R9 ep passthrough", DW'(fab_req_ep), 6);
    req_op = 2'd0; req_ep = 3'd7;
    #1;
    chk("R9 load forwarded", DW'(fab_req_valid), 1);
    chk("R9 op passthrough", DW'(fab_req_op), 0);
    req_valid = 1'b0;
    complete(2'd0, 7, 2'd0, 64'h42);
    chk("R10 load ones", rsp_data, ONES);
    complete(2'd2, 7, 2'd0, 64'h42);
    chk("R10 cfg ones", rsp_data, ONES);
    chk("R10 cfg not ok", DW'(rsp_cfg_ok), 0);
    contain_en = '0;
    complete(2'd1, 7, 2'd2, 64'h0);
    chk("R10 err on stopped no mc", DW'(mc_out), 0);
    clear_all();
  endtask

  task automatic t_cfg();
    complete(2'd2, 4, 2'd0, 64'hABCD);
    chk("R11 ok data", rsp_data, 64'hABCD);
    chk("R11 ok flag", DW'(rsp_cfg_ok), 1);
    contain_en = 8'h10;
    complete(2'd2, 4, 2'd1, 64'hABCD);
    chk("R11 norsp ones", rsp_data, ONES);
    chk("R11 norsp flag", DW'(rsp_cfg_ok), 1);
    chk("R11 norsp no stop", DW'(ep_stopped), 0);
    complete(2'd2, 4, 2'd2, 64'hABCD);
    chk("R11 err flag", DW'(rsp_cfg_ok), 0);
    chk("R11 err stop", DW'(ep_stopped), DW'(8'h10));
    contain_en = '0;
    clear_all();
    complete(2'd2, 4, 2'd2, 64'hABCD);
    chk("R11 err mc", DW'(mc_out), DW'(4'hF));
  endtask

  task automatic t_clear();
    contain_en = 8'h09;
    complete(2'd1, 0, 2'd2, 64'h0);
    chk("R12 setup", DW'(ep_stopped), DW'(8'h01));
    @(negedge clk);
    clr_stop = 8'h01;
    @(negedge clk);
    clr_stop = '0;
    chk("R12 cleared", DW'(ep_stopped), 0);
    clr_stop = 8'h08; fatal_err = 8'h08;
    @(negedge clk);
    clr_stop = '0; fatal_err = '0;
    chk("R12 set wins", DW'(ep_stopped), DW'(8'h08));
    contain_en = '0;
    clear_all();
  endtask

  task automatic t_dma_quiet();
    complete(2'd3, 2, 2'd0, 64'h0);
    chk("R13 ok no rsp", DW'(rsp_valid), 0);
    chk("R13 ok no mc", DW'(mc_out), 0);
    complete(2'd3, 2, 2'd1, 64'h0);
    chk("R13 norsp no mc", DW'(mc_out), 0);
    chk("R13 norsp no stop", DW'(ep_stopped), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_ok();
    t_norsp();
    t_err_uncontained();
    t_err_contained();
    t_fatal();
    t_mc_multi();
    t_stopped_traffic();
    t_cfg();
    t_clear();
    t_dma_quiet();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule